// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one of five on-chip PLLs without ever exposing downstream logic to an unsettled clock. A request carries a PLL index and four integer divider values: reference divider, feedback multiplier and two post dividers. The block first works out the VCO frequency, which is a 24 MHz reference times the feedback multiplier over the reference divider. It then works out the output frequency, which is the VCO frequency over both post dividers. Both figures are in kHz and come from a shared bit-serial divider. If any limit is broken, the request ends at once with an error and no register is touched.

A legal request runs a fixed chain of read-modify-write accesses on a small register port. It drops the chosen PLL to its slow (bypass) mode. It forces integer mode, loads the multiplier and first post divider, and then loads the second post divider and reference divider. It polls the lock flag until lock is seen or a cycle budget runs out. Only after lock does it return the PLL to normal mode. Because every write is a read-modify-write, each access changes only the fields that access owns.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0 and neither register strobe is active until a request is accepted.
- R2: A request fails with `err`=1, and issues no register read or write, when any of these holds: refdiv is 0, either post divider is 0, fbdiv is outside 16..3200, floor(24000*fbdiv/refdiv) kHz is outside 800000..3200000, or that VCO value divided by postdiv1*postdiv2 (floor) is outside 16000..3200000.
- R3: A PLL index of 5, 6 or 7 fails with `err`=1 and issues no register access.
- R4: Register map: address 15 is the mode register, 2k is config word 0 of PLL k and 2k+1 is config word 1. A read returns data on `reg_rdata` the cycle after `reg_rd_en`. A legal request writes in this order: mode, word 1, word 0, word 1, and finally mode.
- R5: The mode bit of PLL index 0,1,2,3,4 is bit 0,1,4,8,12 respectively. The first write clears only that bit, the config writes happen while it is 0, and the last write sets only that bit.
- R6: In config word 0 the feedback multiplier goes to bits 11:0 and postdiv1 to bits 14:12; bit 15 keeps its value.
- R7: In config word 1 the integer-mode bit 12 is set to 1, postdiv2 goes to bits 8:6 and refdiv to bits 5:0; all other bits keep their values.
- R8: Lock is taken from bit 10 of config word 1 by repeated reads; the return to normal mode is written only after a read has shown the bit set.
- R9: If lock is not seen within LOCK_TIMEOUT cycles of polling, the request ends with `err`=1 after four writes, and the PLL stays in slow mode.
- R10: `busy` rises the cycle after an accepted `start` and falls in the same cycle as `done`. `done` is a single-cycle pulse. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| pll_sel | input | SEL_W | PLL index 0..4 |
| fbdiv | input | FB_W | Feedback multiplier |
| refdiv | input | REF_W | Reference divider |
| postdiv1 | input | PD_W | First post divider |
| postdiv2 | input | PD_W | Second post divider |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of last request; valid from `done` until next start |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | REG_W | Register write data |
| reg_rdata | input | REG_W | Register read data, one cycle after the strobe |

## Verification
The bench keeps every default except LOCK_TIMEOUT, which it lowers to 64. With that value the give-up path of the lock poll is reached in a short run, and a lock that arrives after 40 cycles still exercises many poll rounds before success. The default 24 MHz reference and frequency limits put the exact VCO edges within reach of a sweep over ten multipliers, five reference dividers and fifteen post-divider pairs: multipliers 33 and 34 straddle the lower VCO bound, and 133 and 134 straddle the upper bound. Rotating the PLL index through all eight codes covers every mode-bit position and the invalid indices.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  // Field placement inside the two configuration words
  localparam int C0_FB_LSB   = 0;
  localparam int C0_PD1_LSB  = 12;
  localparam int C1_REF_LSB  = 0;
  localparam int C1_PD2_LSB  = 6;
  localparam int C1_LOCK_BIT = 10;
  localparam int C1_INT_BIT  = 12;

  // Ordered steps of a reprogramming pass
  typedef enum logic [2:0] {
    STP_SLOW = 3'd0,
    STP_INT  = 3'd1,
    STP_C0   = 3'd2,
    STP_C1   = 3'd3,
    STP_POLL = 3'd4,
    STP_NORM = 3'd5
  } step_e;

  // Mode-register bit owned by each PLL index
  function automatic logic [3:0] mode_bit_pos(input logic [2:0] sel);
    case (sel)
      3'd0:    mode_bit_pos = 4'd0;
      3'd1:    mode_bit_pos = 4'd1;
      3'd2:    mode_bit_pos = 4'd4;
      3'd3:    mode_bit_pos = 4'd8;
      default: mode_bit_pos = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/pll_serial_div.sv
module pll_serial_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    ge    = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0; den_q <= '0; quo_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        quo_q <= num;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/pll_range_chk.sv
module pll_range_chk #(
  parameter int FB_W        = 12,
  parameter int REF_W       = 6,
  parameter int PD_W        = 3,
  parameter int REF_KHZ     = 24000,
  parameter int VCO_MIN_KHZ = 800000,
  parameter int VCO_MAX_KHZ = 3200000,
  parameter int OUT_MIN_KHZ = 16000,
  parameter int OUT_MAX_KHZ = 3200000,
  parameter int FB_MIN      = 16,
  parameter int FB_MAX      = 3200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [FB_W-1:0]  fbdiv,
  input  logic [REF_W-1:0] refdiv,
  input  logic [PD_W-1:0]  pd1,
  input  logic [PD_W-1:0]  pd2,
  output logic             done,
  output logic             ok
);
  localparam int NUM_W = $clog2(REF_KHZ) + FB_W;
  localparam int DEN_W = (REF_W > 2 * PD_W) ? REF_W : 2 * PD_W;

  typedef enum logic [1:0] {CK_IDLE, CK_VCO, CK_OUT} ck_e;

  ck_e              st_q;
  logic             div_go_q, div_done, done_q, ok_q;
  logic [NUM_W-1:0] div_num_q, div_quo;
  logic [DEN_W-1:0] div_den_q, prod_q;
  logic             pre_bad;

  pll_serial_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go_q), .num(div_num_q), .den(div_den_q),
    .done(div_done), .quo(div_quo)
  );

  always_comb begin
    pre_bad = (refdiv == '0) || (pd1 == '0) || (pd2 == '0) ||
              (fbdiv < FB_W'(FB_MIN)) || (fbdiv > FB_W'(FB_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= CK_IDLE; div_go_q <= 1'b0; done_q <= 1'b0; ok_q <= 1'b0;
      div_num_q <= '0; div_den_q <= '0; prod_q <= '0;
    end else begin
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      case (st_q)
        CK_IDLE: if (go) begin
          if (pre_bad) begin
            done_q <= 1'b1;
            ok_q   <= 1'b0;
          end else begin
            div_num_q <= NUM_W'(REF_KHZ) * NUM_W'(fbdiv);
            div_den_q <= DEN_W'(refdiv);
            prod_q    <= DEN_W'(pd1) * DEN_W'(pd2);
            div_go_q  <= 1'b1;
            st_q      <= CK_VCO;
          end
        end
        CK_VCO: if (div_done) begin
          if (div_quo < NUM_W'(VCO_MIN_KHZ) || div_quo > NUM_W'(VCO_MAX_KHZ)) begin
            done_q <= 1'b1;
            ok_q   <= 1'b0;
            st_q   <= CK_IDLE;
          end else begin
            div_num_q <= div_quo;
            div_den_q <= prod_q;
            div_go_q  <= 1'b1;
            st_q      <= CK_OUT;
          end
        end
        CK_OUT: if (div_done) begin
          done_q <= 1'b1;
          ok_q   <= (div_quo >= NUM_W'(OUT_MIN_KHZ)) && (div_quo <= NUM_W'(OUT_MAX_KHZ));
          st_q   <= CK_IDLE;
        end
        default: st_q <= CK_IDLE;
      endcase
    end
  end

  assign done = done_q;
  assign ok   = ok_q;
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int NUM_PLL      = 5,
  parameter int SEL_W        = 3,
  parameter int FB_W         = 12,
  parameter int REF_W        = 6,
  parameter int PD_W         = 3,
  parameter int REG_W        = 16,
  parameter int ADDR_W       = 4,
  parameter int LOCK_TIMEOUT = 4096,
  parameter int REF_KHZ      = 24000,
  parameter int VCO_MIN_KHZ  = 800000,
  parameter int VCO_MAX_KHZ  = 3200000,
  parameter int OUT_MIN_KHZ  = 16000,
  parameter int OUT_MAX_KHZ  = 3200000,
  parameter int FB_MIN       = 16,
  parameter int FB_MAX       = 3200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  pll_sel,
  input  logic [FB_W-1:0]   fbdiv,
  input  logic [REF_W-1:0]  refdiv,
  input  logic [PD_W-1:0]   postdiv1,
  input  logic [PD_W-1:0]   postdiv2,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(2 ** ADDR_W - 1);
  localparam int TMO_W = $clog2(LOCK_TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_MOD, S_WR, S_FIN} st_e;

  st_e              st_q;
  step_e            step_q, step_nx;
  logic [SEL_W-1:0] sel_q;
  logic [FB_W-1:0]  fb_q;
  logic [REF_W-1:0] ref_q;
  logic [PD_W-1:0]  pd1_q, pd2_q;
  logic [TMO_W-1:0] tmo_q;
  logic             busy_q, done_q, err_q, fail_q, chk_go_q;
  logic             rd_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0] wdata_q, mbit, fmask, fval;
  logic             chk_done, chk_ok;

  function automatic logic [ADDR_W-1:0] addr_of(input step_e s, input logic [SEL_W-1:0] sel);
    case (s)
      STP_SLOW, STP_NORM: addr_of = MODE_ADDR;
      STP_C0:             addr_of = ADDR_W'({sel, 1'b0});
      default:            addr_of = ADDR_W'({sel, 1'b1});
    endcase
  endfunction

  pll_range_chk #(
    .FB_W(FB_W), .REF_W(REF_W), .PD_W(PD_W), .REF_KHZ(REF_KHZ),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ),
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
  ) u_rng (
    .clk(clk), .rst(rst), .go(chk_go_q), .fbdiv(fb_q), .refdiv(ref_q),
    .pd1(pd1_q), .pd2(pd2_q), .done(chk_done), .ok(chk_ok)
  );

  // Field mask and value that the current step merges into the read word
  always_comb begin
    mbit    = REG_W'(1) << mode_bit_pos(3'(sel_q));
    step_nx = step_e'(step_q + 3'd1);
    case (step_q)
      STP_SLOW: begin fmask = mbit; fval = '0; end
      STP_INT:  begin fmask = REG_W'(1) << C1_INT_BIT; fval = fmask; end
      STP_C0: begin
        fmask = (REG_W'((2 ** FB_W) - 1) << C0_FB_LSB) | (REG_W'((2 ** PD_W) - 1) << C0_PD1_LSB);
        fval  = (REG_W'(fb_q) << C0_FB_LSB) | (REG_W'(pd1_q) << C0_PD1_LSB);
      end
      STP_C1: begin
        fmask = (REG_W'((2 ** REF_W) - 1) << C1_REF_LSB) | (REG_W'((2 ** PD_W) - 1) << C1_PD2_LSB);
        fval  = (REG_W'(ref_q) << C1_REF_LSB) | (REG_W'(pd2_q) << C1_PD2_LSB);
      end
      STP_NORM: begin fmask = mbit; fval = mbit; end
      default:  begin fmask = '0; fval = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; step_q <= STP_SLOW; sel_q <= '0; fb_q <= '0; ref_q <= '0;
      pd1_q <= '0; pd2_q <= '0; tmo_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
      err_q <= 1'b0; fail_q <= 1'b0; chk_go_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
    end else begin
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      chk_go_q <= 1'b0;
      if (step_q == STP_POLL && (st_q == S_RD || st_q == S_MOD) &&
          tmo_q != TMO_W'(LOCK_TIMEOUT))
        tmo_q <= tmo_q + 1'b1;
      case (st_q)
        S_IDLE: if (start) begin
          sel_q <= pll_sel; fb_q <= fbdiv; ref_q <= refdiv;
          pd1_q <= postdiv1; pd2_q <= postdiv2;
          busy_q <= 1'b1; err_q <= 1'b0; fail_q <= 1'b0;
          if (pll_sel >= SEL_W'(NUM_PLL)) begin
            fail_q <= 1'b1;
            st_q   <= S_FIN;
          end else begin
            chk_go_q <= 1'b1;
            st_q     <= S_CHK;
          end
        end
        S_CHK: if (chk_done) begin
          if (chk_ok) begin
            step_q <= STP_SLOW;
            rd_q   <= 1'b1;
            addr_q <= MODE_ADDR;
            st_q   <= S_RD;
          end else begin
            fail_q <= 1'b1;
            st_q   <= S_FIN;
          end
        end
        S_RD: st_q <= S_MOD;
        S_MOD: begin
          if (step_q == STP_POLL) begin
            if (reg_rdata[C1_LOCK_BIT]) begin
              step_q <= STP_NORM;
              rd_q   <= 1'b1;
              addr_q <= MODE_ADDR;
              st_q   <= S_RD;
            end else if (tmo_q == TMO_W'(LOCK_TIMEOUT)) begin
              fail_q <= 1'b1;
              st_q   <= S_FIN;
            end else begin
              rd_q <= 1'b1;
              st_q <= S_RD;
            end
          end else begin
            wr_q    <= 1'b1;
            wdata_q <= (reg_rdata & ~fmask) | (fval & fmask);
            st_q    <= S_WR;
          end
        end
        S_WR: begin
          if (step_q == STP_NORM) begin
            st_q <= S_FIN;
          end else begin
            step_q <= step_nx;
            rd_q   <= 1'b1;
            addr_q <= addr_of(step_nx, sel_q);
            st_q   <= S_RD;
            if (step_nx == STP_POLL) tmo_q <= '0;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          err_q  <= fail_q;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign reg_rd_en = rd_q;
  assign reg_wr_en = wr_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic reg_rd_en,
  input logic reg_wr_en
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_drops_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_en && reg_wr_en));
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!reg_rd_en && !reg_wr_en));
  a_r2_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_sva (.*);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  pll_sel = '0;
  logic [11:0] fbdiv = '0;
  logic [5:0]  refdiv = '0;
  logic [2:0]  postdiv1 = '0, postdiv2 = '0;
  logic        busy, done, err, rd_en, wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;

  pll_reprog_seq #(.LOCK_TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pll_sel(pll_sel), .fbdiv(fbdiv),
    .refdiv(refdiv), .postdiv1(postdiv1), .postdiv2(postdiv2), .busy(busy),
    .done(done), .err(err), .reg_rd_en(rd_en), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  // Register file model with a lock flag that follows config writes
  logic [15:0] preset [16];
  logic [15:0] regs [16];
  logic        load = 1'b0;
  int          lock_dly = 3;
  bit          never_lock = 1'b0;
  int          lock_cnt, wr_cnt, rd_cnt;
  logic [3:0]  wlog_addr [32];
  logic [15:0] wlog_data [32];
  logic [15:0] wlog_mode [32];
  bit          wlog_lock [32];
  wire         locked = (lock_cnt == 0) && !never_lock;

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 16; i++) regs[i] <= preset[i];
      wr_cnt <= 0; rd_cnt <= 0; lock_cnt <= 0; rdata <= '0;
    end else begin
      if (rd_en) begin
        rd_cnt <= rd_cnt + 1;
        if (addr < 4'd10 && addr[0])
          rdata <= (regs[addr] & ~16'h0400) | (locked ? 16'h0400 : 16'h0000);
        else
          rdata <= regs[addr];
      end
      if (wr_en) begin
        if (wr_cnt < 32) begin
          wlog_addr[wr_cnt] <= addr;
          wlog_data[wr_cnt] <= wdata;
          wlog_mode[wr_cnt] <= regs[15];
          wlog_lock[wr_cnt] <= locked;
        end
        wr_cnt <= wr_cnt + 1;
        regs[addr] <= (addr < 4'd10 && addr[0]) ? (wdata & ~16'h0400) : wdata;
        if (addr < 4'd10) lock_cnt <= lock_dly;
      end else if (lock_cnt > 0) begin
        lock_cnt <= lock_cnt - 1;
      end
    end
  end

  int nchk = 0, nerr = 0, op_idx = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal_f(input int fb, input int rf, input int p1, input int p2);
    longint vco, outk;
    if (rf == 0 || p1 == 0 || p2 == 0) return 1'b0;
    if (fb < 16 || fb > 3200) return 1'b0;
    vco = 64'd24000 * fb / rf;
    if (vco < 800000 || vco > 3200000) return 1'b0;
    outk = vco / (p1 * p2);
    return (outk >= 16000 && outk <= 3200000);
  endfunction

  function automatic int mode_pos(input int sel);
    case (sel)
      0: return 0;
      1: return 1;
      2: return 4;
      3: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic run_op(input int sel, input int fb, input int rf, input int p1,
                        input int p2, input int dly, input bit nev, input bit poke);
    bit valid, leg, exp_err;
    int n;
    logic [15:0] mb, e0, e1;
    int c0, c1;
    op_idx++;
    for (int i = 0; i < 16; i++)
      preset[i] = (16'h3C96 ^ 16'(i * 16'h1357) ^ 16'(op_idx * 16'h0B1D)) & ~16'h0400;
    lock_dly   = dly;
    never_lock = nev;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    pll_sel = 3'(sel); fbdiv = 12'(fb); refdiv = 6'(rf);
    postdiv1 = 3'(p1); postdiv2 = 3'(p2); start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10 busy after start", busy, 1);
    if (poke) begin
      repeat (8) @(negedge clk);
      pll_sel = 3'd0; fbdiv = 12'd100; refdiv = 6'd1; postdiv1 = 3'd3; postdiv2 = 3'd1;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", done, 1);
    if (!done) return;
    chk("R10 busy low with done", busy, 0);
    valid   = sel < 5;
    leg     = legal_f(fb, rf, p1, p2);
    exp_err = !valid || !leg || nev;
    chk(valid ? (leg ? "R9 err flag" : "R2 err flag") : "R3 err flag", err, exp_err);
    @(negedge clk);
    chk("R10 done single pulse", done, 0);
    if (!valid || !leg) begin
      chk(valid ? "R2 no writes" : "R3 no writes", wr_cnt, 0);
      chk(valid ? "R2 no reads" : "R3 no reads", rd_cnt, 0);
      return;
    end
    mb = 16'(1) << mode_pos(sel);
    c0 = 2 * sel;
    c1 = 2 * sel + 1;
    chk("R4 first write mode", wlog_addr[0], 15);
    chk("R4 second write word1", wlog_addr[1], c1);
    chk("R4 third write word0", wlog_addr[2], c0);
    chk("R4 fourth write word1", wlog_addr[3], c1);
    chk("R5 slow write value", wlog_data[0], preset[15] & ~mb);
    chk("R5 slow during config", wlog_mode[2] & mb, 0);
    e0 = {preset[c0][15], 3'(p1), 12'(fb)};
    chk("R6 word0 fields", regs[c0], e0);
    e1 = (preset[c1] & ~16'h11FF) | 16'h1000 | (16'(p2) << 6) | 16'(rf);
    chk("R7 word1 fields", regs[c1] & ~16'h0400, e1);
    if (!nev) begin
      chk("R4 write count", wr_cnt, 5);
      chk("R4 last write mode", wlog_addr[4], 15);
      chk("R8 lock seen before normal", wlog_lock[4], 1);
      chk("R5 normal mode value", regs[15], preset[15] | mb);
    end else begin
      chk("R9 write count", wr_cnt, 4);
      chk("R9 stays slow", regs[15] & mb, 0);
    end
    if (poke) begin
      repeat (300) @(negedge clk);
      chk("R10 start while busy ignored", wr_cnt, 5);
      chk("R10 idle after ignored start", busy, 0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  localparam int FBL [10] = '{15, 16, 33, 34, 100, 133, 134, 3200, 3201, 4095};
  localparam int RFL [5]  = '{0, 1, 2, 3, 63};
  localparam int P1L [5]  = '{0, 1, 2, 4, 7};
  localparam int P2L [3]  = '{1, 3, 7};

  initial begin
    for (int i = 0; i < 16; i++) preset[i] = '0;
    rst = 1'b1;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 busy after reset", busy, 0);
      chk("R1 done after reset", done, 0);
      chk("R1 err after reset", err, 0);
      chk("R1 no read after reset", rd_en, 0);
      chk("R1 no write after reset", wr_en, 0);
    end
    // Directed cases
    run_op(4, 50, 1, 2, 1, 3, 1'b0, 1'b0);
    run_op(3, 75, 2, 1, 1, 40, 1'b0, 1'b0);   // R8 long lock wait
    run_op(2, 50, 1, 2, 1, 3, 1'b1, 1'b0);    // R9 lock never arrives
    run_op(1, 100, 3, 4, 1, 3, 1'b0, 1'b1);   // R10 start while busy
    run_op(6, 50, 1, 2, 1, 3, 1'b0, 1'b0);    // R3 invalid index
    // Sweep of divider combinations, PLL index rotating through all codes
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 3; d++)
            run_op((a * 75 + b * 15 + c * 3 + d) % 8, FBL[a], RFL[b], P1L[c], P2L[d],
                   3, 1'b0, 1'b0);
    finish_run();
  end
endmodule